// File: doc/BRIEF.md
# Clock Synthesizer Lock Supervisor

This block watches an on-chip clock synthesizer and restarts it whenever it is not running properly. It is clocked by the synthesizer's own reference input clock. When it starts, it drives a reset pulse into the synthesizer that lasts exactly one clock. It then lets a settling time pass that is long enough for lock to be reached, and then it looks at three status flags: locked, reference-clock-stopped and synthesized-output-stopped. If any of them shows trouble, it pulses reset again and repeats the wait. If all is well, it raises a healthy indication and looks again one interval later. This continues for as long as the block runs.

A single down-counter sets the length of every wait. The wait length is a parameter counted in input-clock cycles: cycles per microsecond times microseconds, with 25 cycles per microsecond as the default. All status flags pass through a two-stage synchronizer before they are used. While the reference clock is reported stopped, the block stays idle. Once the flag clears, it restarts with a reset pulse. A saturating counter reports how many reset pulses have been issued.

Top module: `clk_lock_watchdog`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `mgr_reset_o` and `healthy_o` are 0 and `retry_count_o` is 0.
- R2: Every reset pulse on `mgr_reset_o` is high for exactly one clock cycle.
- R3: After a reset pulse, status is evaluated once WAIT cycles have passed (WAIT = CLK_PER_US × WAIT_US). If that evaluation fails, the next pulse begins exactly WAIT+1 cycles after the previous pulse began.
- R4: A low locked flag at an evaluation counts as a fault and triggers a new reset pulse.
- R5: An evaluation with no fault produces no pulse and sets `healthy_o` to 1. Evaluation then repeats every WAIT cycles. `healthy_o` is 0 during every reset pulse and while the block is idle.
- R6: When CHECK_OUT_STOP is 1, a high synthesized-output-stopped flag at an evaluation is a fault. When CHECK_OUT_STOP is 0, that flag is ignored.
- R7: While the synchronized reference-stopped flag is high, the block is idle: it issues no pulse and `healthy_o` is 0. When the flag is cleared at the input, a reset pulse appears on the third rising edge after the change.
- R8: `retry_count_o` increases by 1 with each reset pulse. It stops at 2^RETRY_W − 1 and stays there.
- R9: Each status input acts through two synchronizing flops, so a change at an input affects the block's decisions two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesizer reference input clock |
| rst | input | 1 | Synchronous active-high reset |
| locked_i | input | 1 | Lock flag from the synthesizer |
| clkin_stopped_i | input | 1 | Reference-clock-stopped flag |
| synth_stopped_i | input | 1 | Synthesized-output-stopped flag |
| mgr_reset_o | output | 1 | One-cycle reset pulse to the synthesizer |
| healthy_o | output | 1 | High after a passing evaluation, until the next pulse or idle period |
| retry_count_o | output | RETRY_W | Saturating count of reset pulses |

## Verification
The hardest states to reach are retry saturation and the idle hold. Saturation needs many consecutive failed evaluations. The bench keeps the locked flag low across more than 2^RETRY_W full wait windows while timing each gap between pulses. The idle hold is entered from a stream of output-stopped faults; the bench then checks the exact restart latency once the stopped flag is released. A second instance with the output-stopped check disabled receives the same stimulus, which shows that this flag is ignored there.

// File: rtl/cmw_pkg.sv
package cmw_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_PULSE = 2'd1,
    ST_WAIT  = 2'd2
  } cmw_state_e;
endpackage

// File: rtl/cmw_sync.sv
module cmw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
    // each stage lags its predecessor by one clock (R9)
    assert_stage_lag_R9: assert property (@(posedge clk) disable iff (rst)
      stg[i] == $past(stg[i-1]));
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cmw_wait_ctr.sv
module cmw_wait_ctr #(
  parameter int WAIT_CYCLES = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WAIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start)         cnt_q <= RELOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/cmw_fsm.sv
module cmw_fsm
  import cmw_pkg::*;
#(
  parameter int   RETRY_W        = 4,
  parameter logic CHECK_OUT_STOP = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               locked_s,
  input  logic               istop_s,
  input  logic               ostop_s,
  input  logic               done,
  output logic               start,
  output logic               pulse_o,
  output logic               healthy_o,
  output logic [RETRY_W-1:0] retry_o
);
  localparam logic [RETRY_W-1:0] RETRY_MAX = '1;

  cmw_state_e st_q, nxt;
  logic       fault, pass;

  assign fault = !locked_s || istop_s || (CHECK_OUT_STOP && ostop_s);

  always_comb begin
    nxt   = st_q;
    start = 1'b0;
    pass  = 1'b0;
    case (st_q)
      ST_HOLD:  if (!istop_s) nxt = ST_PULSE;
      ST_PULSE: begin
        nxt   = ST_WAIT;
        start = 1'b1;
      end
      ST_WAIT: begin
        if (istop_s) nxt = ST_HOLD;
        else if (done) begin
          if (fault) nxt = ST_PULSE;
          else begin
            start = 1'b1;
            pass  = 1'b1;
          end
        end
      end
      default: nxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_HOLD;
      pulse_o   <= 1'b0;
      healthy_o <= 1'b0;
      retry_o   <= '0;
    end else begin
      st_q    <= nxt;
      pulse_o <= (nxt == ST_PULSE);
      if (nxt != ST_WAIT) healthy_o <= 1'b0;
      else if (pass)      healthy_o <= 1'b1;
      if (nxt == ST_PULSE && retry_o != RETRY_MAX) retry_o <= retry_o + 1'b1;
    end
  end

  assert_pulse_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  assert_no_pulse_mid_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && !done && !istop_s) |=> !pulse_o);
  assert_healthy_low_on_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> !healthy_o);
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD && istop_s) |=> (!pulse_o && !healthy_o));
  assert_retry_step_R8: assert property (@(posedge clk) disable iff (rst)
    (retry_o != $past(retry_o)) |-> (pulse_o && retry_o == $past(retry_o) + 1'b1));
  assert_retry_saturate_R8: assert property (@(posedge clk) disable iff (rst)
    (retry_o == RETRY_MAX) |=> (retry_o == RETRY_MAX));
endmodule

// File: rtl/clk_lock_watchdog.sv
module clk_lock_watchdog #(
  parameter int   CLK_PER_US     = 25,
  parameter int   WAIT_US        = 2,
  parameter int   RETRY_W        = 4,
  parameter logic CHECK_OUT_STOP = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               locked_i,
  input  logic               clkin_stopped_i,
  input  logic               synth_stopped_i,
  output logic               mgr_reset_o,
  output logic               healthy_o,
  output logic [RETRY_W-1:0] retry_count_o
);
  localparam int WAIT_CYCLES = CLK_PER_US * WAIT_US;
  localparam int N_FLAGS     = 3;

  logic [N_FLAGS-1:0] flags_s;
  logic               start, done;

  cmw_sync #(.WIDTH(N_FLAGS), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({synth_stopped_i, clkin_stopped_i, locked_i}),
    .q   (flags_s)
  );

  cmw_wait_ctr #(.WAIT_CYCLES(WAIT_CYCLES)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .done  (done)
  );

  cmw_fsm #(.RETRY_W(RETRY_W), .CHECK_OUT_STOP(CHECK_OUT_STOP)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .locked_s  (flags_s[0]),
    .istop_s   (flags_s[1]),
    .ostop_s   (flags_s[2]),
    .done      (done),
    .start     (start),
    .pulse_o   (mgr_reset_o),
    .healthy_o (healthy_o),
    .retry_o   (retry_count_o)
  );
endmodule

// File: tb/test_clk_lock_watchdog.sv
module test_clk_lock_watchdog;
  localparam int CPU  = 25;
  localparam int WUS  = 1;
  localparam int W    = CPU * WUS;
  localparam int RW   = 3;
  localparam int RMAX = (1 << RW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic locked = 1'b0, istop = 1'b0, ostop = 1'b0;
  logic mrst, hlt, mrst_n, hlt_n;
  logic [RW-1:0] rty, rty_n;

  int errors = 0, checks = 0;
  bit armed = 0, finished = 0;

  always #10 clk = ~clk;

  clk_lock_watchdog #(.CLK_PER_US(CPU), .WAIT_US(WUS), .RETRY_W(RW), .CHECK_OUT_STOP(1'b1)) i_clk_lock_watchdog (
    .clk(clk), .rst(rst), .locked_i(locked), .clkin_stopped_i(istop), .synth_stopped_i(ostop),
    .mgr_reset_o(mrst), .healthy_o(hlt), .retry_count_o(rty));

  clk_lock_watchdog #(.CLK_PER_US(CPU), .WAIT_US(WUS), .RETRY_W(RW), .CHECK_OUT_STOP(1'b0)) i_clk_lock_watchdog_noout (
    .clk(clk), .rst(rst), .locked_i(locked), .clkin_stopped_i(istop), .synth_stopped_i(ostop),
    .mgr_reset_o(mrst_n), .healthy_o(hlt_n), .retry_count_o(rty_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 pulse, 2 waiting
  int m_st, m_cnt, m_h, m_p, m_r;
  logic [2:0] q1, q2;
  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_h = 0; m_p = 0; m_r = 0; q1 = '0; q2 = '0;
      armed = 1;
    end else begin
      bit lk, is, os, flt;
      lk = q2[0]; is = q2[1]; os = q2[2];
      flt = !lk || is || os;
      case (m_st)
        0: if (!is) m_st = 1;
        1: begin m_st = 2; m_cnt = W - 1; end
        default: begin
          if (is) m_st = 0;
          else if (m_cnt == 0) begin
            if (flt) m_st = 1;
            else begin m_cnt = W - 1; m_h = 1; end
          end else m_cnt--;
        end
      endcase
      m_p = (m_st == 1);
      if (m_st != 2) m_h = 0;
      if (m_st == 1 && m_r < RMAX) m_r++;
      q2 = q1;
      q1 = {ostop, istop, locked};
    end
  end

  bit prev_p = 0;
  int noout_pulses = 0;
  always @(negedge clk) begin
    if (armed) begin
      check(mrst == m_p[0], "R2/R9 model pulse", mrst, m_p);
      check(hlt == m_h[0], "R5/R9 model healthy", hlt, m_h);
      check(int'(rty) == m_r, "R8/R9 model retry", rty, m_r);
      if (prev_p) check(!mrst, "R2 pulse width", mrst, 0);
      prev_p = mrst;
      if (mrst_n) noout_pulses++;
    end
  end

  task automatic to_pulse(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!mrst && n < 10 * W);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, base, cnt0;
    repeat (5) @(negedge clk);
    check(!mrst && !hlt && rty == 0, "R1 reset state", {mrst, hlt, rty}, 0);
    rst = 1'b0;
    to_pulse(n);
    check(n == 1, "R1 first pulse latency", n, 1);
    // locked held low: repeated retries
    for (int i = 0; i < RMAX + 2; i++) begin
      to_pulse(n);
      check(n == W + 1, "R3 R4 pulse spacing", n, W + 1);
    end
    check(int'(rty) == RMAX, "R8 saturation", rty, RMAX);
    // lock acquired
    locked = 1'b1;
    repeat (3 * W) @(negedge clk);
    check(hlt == 1'b1, "R5 healthy after pass", hlt, 1);
    base = 0;
    for (int i = 0; i < 2 * W; i++) begin @(negedge clk); if (mrst) base++; end
    check(base == 0, "R5 no pulse while healthy", base, 0);
    check(hlt == 1'b1, "R5 healthy persists", hlt, 1);
    // output-stopped fault
    cnt0 = noout_pulses;
    ostop = 1'b1;
    to_pulse(n);
    check(n <= W + 3, "R6 out-stop triggers reset", n, W + 3);
    repeat (2 * W) @(negedge clk);
    check(hlt_n == 1'b1, "R6 ignored when disabled healthy", hlt_n, 1);
    check(noout_pulses == cnt0, "R6 ignored when disabled pulses", noout_pulses - cnt0, 0);
    // reference clock stopped
    istop = 1'b1;
    repeat (4) @(negedge clk);
    base = 0;
    for (int i = 0; i < 4 * W; i++) begin @(negedge clk); if (mrst) base++; end
    check(base == 0, "R7 idle no pulse", base, 0);
    check(hlt == 1'b0, "R7 idle not healthy", hlt, 0);
    ostop = 1'b0;
    istop = 1'b0;
    to_pulse(n);
    check(n == 3, "R7 restart latency", n, 3);
    // short locked glitch away from evaluation point
    repeat (W / 2) @(negedge clk);
    locked = 1'b0;
    @(negedge clk);
    locked = 1'b1;
    repeat (3 * W) @(negedge clk);
    check(hlt == 1'b1, "R9 glitch not at evaluation", hlt, 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule